// File: doc/BRIEF.md
# Trigger Bus Front-End Synchronizer

This block distributes triggers from one central master to a set of front-end nodes. It also checks that the nodes stay in step on event numbering. When a trigger request is accepted, the master places a one-cycle strobe on a shared bus. The strobe carries a 4-bit trigger class and the low 8 bits of the master's event number. Each front-end node has a small multi-event buffer. It asserts busy only when that buffer cannot take another event. The master sees the OR of all busy lines and refuses requests while it is high. It counts every refused request, and every suppressed delayed trigger, in a saturating counter.

Each node keeps its own 8-bit event counter and compares it with the broadcast number on every trigger it receives. When they differ, the node raises a sticky per-node flag and realigns its counter to the broadcast number. It still stores its own pre-realignment number with the event. The event-builder stage pops one event from every node at once over a valid/ready stream and reports whether the nodes agree on the event number. When the builder's valid is high and ready is low, the offered event stays unchanged, and nothing is removed from any buffer.

The master can also issue a second, delayed trigger a programmable number of cycles after each primary trigger. This is set by configuration alone.

Top module: `trig_sync_top`

## Requirements
- R1: An accepted request, seen as `trig_req` high while `busy` is low, produces `bus_strb` high for one cycle, one clock later. At that cycle `bus_type` carries the requested class and `bus_lsb` carries the master event count. The master count increments by one, wrapping at 8 bits, for every strobe issued, delayed strobes included.
- R2: Every enabled node stores one event per strobe. `eb_valid` is high when every node holds at least one event. It shows node 0's oldest class and number on `eb_type` and `eb_num`. When `eb_valid` and `eb_ready` are both high at a clock edge, one event is removed from every node. While ready is low, valid and data are held.
- R3: `busy` is high when any node buffer holds DEPTH events. It is also high when a node holds DEPTH-1 events while a strobe is on the bus. After one event is popped, `busy` falls in the next cycle.
- R4: A request made while `busy` is high, or in the cycle a delayed trigger falls due, produces no strobe and adds one to `rej_count`. `rej_count` saturates at its maximum.
- R5: Suppose `dly_en` is high and `dly_cycles` is D, not zero, when a primary trigger is accepted. Then a delayed strobe with class `dly_type` appears exactly D cycles after the primary strobe. A later primary trigger restarts the delay.
- R6: A delayed trigger that falls due while `busy` is high produces no strobe and adds one to `rej_count`.
- R7: On each strobe a node receives, it compares its counter with `bus_lsb`. If they differ, the node sets bit i of `fe_mismatch`, which stays set until cleared. It then loads its counter with `bus_lsb`+1. The event it stores carries its own pre-compare count.
- R8: `eb_err` is high with `eb_valid` when any node's oldest event number differs from node 0's.
- R9: After reset, and one cycle after `cnt_clr` is high, the outputs are cleared: no strobe, master count 0, node counters 0, mismatch flags 0, `rej_count` 0, buffers empty, `busy` 0. Any pending delayed trigger is cancelled.
- R10: A node whose bit in `fe_en` is low ignores the strobe. It stores no event and its counter does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clr | input | 1 | Synchronous clear of counters, flags, buffers and delay timer |
| trig_req | input | 1 | Primary trigger request |
| trig_type | input | 4 | Class of the requested trigger |
| dly_en | input | 1 | Enable the delayed trigger |
| dly_cycles | input | DLY_W | Delay in cycles between primary and delayed strobe (0 = none) |
| dly_type | input | 4 | Class sent with the delayed trigger |
| fe_en | input | N_FE | Per-node strobe enable |
| eb_ready | input | 1 | Event builder consumer ready |
| bus_strb | output | 1 | Trigger strobe on the shared bus |
| bus_type | output | 4 | Broadcast trigger class |
| bus_lsb | output | 8 | Broadcast event-number low bits |
| busy | output | 1 | OR of all node busy lines |
| rej_count | output | REJ_W | Saturating count of refused triggers |
| fe_mismatch | output | N_FE | Sticky per-node counter mismatch flags |
| eb_valid | output | 1 | Assembled event available |
| eb_type | output | 4 | Class of the assembled event (node 0) |
| eb_num | output | 8 | Event number of the assembled event (node 0) |
| eb_err | output | 1 | Nodes disagree on the event number |

## Verification
An accepted request shows as a strobe one cycle after the edge that samples it. The stored event reaches `eb_valid`, and mismatch flags become visible, one more cycle after that. A pop changes `busy` and the builder outputs in the cycle after the consuming edge. The bench drives inputs on falling edges and reads outputs on the falling edge after the edge at which each result is due. For the delay check it counts falling edges from the primary strobe and expects the delayed strobe exactly D edges later.

// File: rtl/trig_sync_pkg.sv
package trig_sync_pkg;
  localparam int unsigned CLS_W = 4;
  localparam int unsigned NUM_W = 8;

  typedef struct packed {
    logic [CLS_W-1:0] cls;
    logic [NUM_W-1:0] num;
  } ev_t;
endpackage

// File: rtl/trig_master.sv
module trig_master
  import trig_sync_pkg::*;
#(
  parameter int unsigned DLY_W = 16,
  parameter int unsigned REJ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             req,
  input  logic [CLS_W-1:0] req_cls,
  input  logic             dly_en,
  input  logic [DLY_W-1:0] dly_cycles,
  input  logic [CLS_W-1:0] dly_cls,
  input  logic             busy_any,
  output logic             strb,
  output logic [CLS_W-1:0] strb_cls,
  output logic [NUM_W-1:0] strb_num,
  output logic [REJ_W-1:0] rej
);
  logic [NUM_W-1:0] evt_cnt;
  logic [DLY_W-1:0] tmr;
  logic             due;
  logic             take_pri;
  logic [1:0]       rej_inc;
  logic [REJ_W:0]   rej_sum;

  assign due      = (tmr == DLY_W'(1));
  assign take_pri = req && !busy_any && !due;
  assign rej_inc  = {1'b0, req && (busy_any || due)} + {1'b0, due && busy_any};
  assign rej_sum  = {1'b0, rej} + (REJ_W+1)'(rej_inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb     <= 1'b0;
      strb_cls <= '0;
      strb_num <= '0;
      evt_cnt  <= '0;
      tmr      <= '0;
      rej      <= '0;
    end else if (clr) begin
      strb     <= 1'b0;
      strb_cls <= '0;
      strb_num <= '0;
      evt_cnt  <= '0;
      tmr      <= '0;
      rej      <= '0;
    end else begin
      strb <= 1'b0;
      if (due) begin
        tmr <= '0;
        if (!busy_any) begin
          strb     <= 1'b1;
          strb_cls <= dly_cls;
          strb_num <= evt_cnt;
          evt_cnt  <= evt_cnt + 1'b1;
        end
      end else if (take_pri) begin
        strb     <= 1'b1;
        strb_cls <= req_cls;
        strb_num <= evt_cnt;
        evt_cnt  <= evt_cnt + 1'b1;
        tmr      <= dly_en ? dly_cycles : '0;
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end
      rej <= rej_sum[REJ_W] ? '1 : rej_sum[REJ_W-1:0];
    end
  end
endmodule

// File: rtl/trig_fe_node.sv
module trig_fe_node
  import trig_sync_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             strb,
  input  logic [CLS_W-1:0] bus_cls,
  input  logic [NUM_W-1:0] bus_num,
  input  logic             pop,
  output logic             busy,
  output logic             nonempty,
  output ev_t              head,
  output logic             mismatch
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OW = $clog2(DEPTH + 1);

  ev_t              mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [OW-1:0]    occ;
  logic [NUM_W-1:0] local_cnt;
  logic             take, full, do_pop;

  assign full     = (occ == OW'(DEPTH));
  assign take     = strb && en;
  assign do_pop   = pop && nonempty;
  assign nonempty = (occ != '0);
  assign busy     = full || (occ == OW'(DEPTH - 1) && strb);
  assign head     = mem[rp];

  always_ff @(posedge clk) begin
    if (take && !full) mem[wp] <= '{cls: bus_cls, num: local_cnt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp        <= '0;
      rp        <= '0;
      occ       <= '0;
      local_cnt <= '0;
      mismatch  <= 1'b0;
    end else if (clr) begin
      wp        <= '0;
      rp        <= '0;
      occ       <= '0;
      local_cnt <= '0;
      mismatch  <= 1'b0;
    end else begin
      if (take && !full) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)        rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      occ <= occ + OW'(take && !full) - OW'(do_pop);
      if (take) begin
        if (local_cnt != bus_num) begin
          mismatch  <= 1'b1;
          local_cnt <= bus_num + 1'b1;
        end else begin
          local_cnt <= local_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trig_evt_builder.sv
module trig_evt_builder
  import trig_sync_pkg::*;
#(
  parameter int unsigned N_FE = 4
) (
  input  logic [N_FE-1:0] fe_nonempty,
  input  ev_t [N_FE-1:0]  fe_head,
  input  logic            ready,
  output logic            valid,
  output logic            pop,
  output logic [CLS_W-1:0] cls,
  output logic [NUM_W-1:0] num,
  output logic            err
);
  logic [N_FE-1:0] differs;

  for (genvar i = 0; i < N_FE; i++) begin : g_cmp
    assign differs[i] = (fe_head[i].num != fe_head[0].num);
  end

  assign valid = &fe_nonempty;
  assign pop   = valid && ready;
  assign cls   = fe_head[0].cls;
  assign num   = fe_head[0].num;
  assign err   = valid && (|differs);
endmodule

// File: rtl/trig_sync_top.sv
module trig_sync_top
  import trig_sync_pkg::*;
#(
  parameter int unsigned N_FE  = 4,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DLY_W = 16,
  parameter int unsigned REJ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_clr,
  input  logic             trig_req,
  input  logic [3:0]       trig_type,
  input  logic             dly_en,
  input  logic [DLY_W-1:0] dly_cycles,
  input  logic [3:0]       dly_type,
  input  logic [N_FE-1:0]  fe_en,
  input  logic             eb_ready,
  output logic             bus_strb,
  output logic [3:0]       bus_type,
  output logic [7:0]       bus_lsb,
  output logic             busy,
  output logic [REJ_W-1:0] rej_count,
  output logic [N_FE-1:0]  fe_mismatch,
  output logic             eb_valid,
  output logic [3:0]       eb_type,
  output logic [7:0]       eb_num,
  output logic             eb_err
);
  logic [N_FE-1:0] fe_busy, fe_nonempty;
  ev_t [N_FE-1:0]  fe_head;
  logic            eb_pop;

  trig_master #(.DLY_W(DLY_W), .REJ_W(REJ_W)) u_master (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
    .req(trig_req), .req_cls(trig_type),
    .dly_en(dly_en), .dly_cycles(dly_cycles), .dly_cls(dly_type),
    .busy_any(busy),
    .strb(bus_strb), .strb_cls(bus_type), .strb_num(bus_lsb),
    .rej(rej_count)
  );

  for (genvar i = 0; i < N_FE; i++) begin : g_fe
    trig_fe_node #(.DEPTH(DEPTH)) u_node (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(fe_en[i]),
      .strb(bus_strb), .bus_cls(bus_type), .bus_num(bus_lsb),
      .pop(eb_pop),
      .busy(fe_busy[i]), .nonempty(fe_nonempty[i]),
      .head(fe_head[i]), .mismatch(fe_mismatch[i])
    );
  end

  assign busy = |fe_busy;

  trig_evt_builder #(.N_FE(N_FE)) u_builder (
    .fe_nonempty(fe_nonempty), .fe_head(fe_head), .ready(eb_ready),
    .valid(eb_valid), .pop(eb_pop),
    .cls(eb_type), .num(eb_num), .err(eb_err)
  );
endmodule

// File: rtl/trig_sync_chk.sv
module trig_sync_chk #(
  parameter int unsigned N_FE  = 4,
  parameter int unsigned REJ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_clr,
  input logic             bus_strb,
  input logic             busy,
  input logic [REJ_W-1:0] rej_count,
  input logic [N_FE-1:0]  fe_mismatch,
  input logic             eb_valid,
  input logic             eb_ready,
  input logic [7:0]       eb_num,
  input logic [3:0]       eb_type,
  input logic             eb_err
);
  // R3
  strb_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strb |-> !$past(busy));

  // R2
  eb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eb_valid && !eb_ready && !cnt_clr) |=> (eb_valid && $stable(eb_num) && $stable(eb_type)));

  // R7
  mismatch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> ((fe_mismatch & $past(fe_mismatch)) == $past(fe_mismatch)));

  // R4
  rej_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (rej_count >= $past(rej_count)));

  // R9
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (!bus_strb && !eb_valid && fe_mismatch == '0 && rej_count == '0));

  // R8
  err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eb_err |-> eb_valid);
endmodule

bind trig_sync_top trig_sync_chk #(.N_FE(N_FE), .REJ_W(REJ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .bus_strb(bus_strb),
  .busy(busy), .rej_count(rej_count), .fe_mismatch(fe_mismatch),
  .eb_valid(eb_valid), .eb_ready(eb_ready), .eb_num(eb_num),
  .eb_type(eb_type), .eb_err(eb_err)
);

// File: tb/test_trig_sync_top.sv
module test_trig_sync_top;
  localparam int unsigned N_FE = 4;
  localparam int unsigned DLY_W = 16;
  localparam int unsigned REJ_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_clr = 1'b0, trig_req = 1'b0, dly_en = 1'b0, eb_ready = 1'b0;
  logic [3:0] trig_type = '0, dly_type = '0;
  logic [DLY_W-1:0] dly_cycles = '0;
  logic [N_FE-1:0] fe_en = '1;
  logic bus_strb, busy, eb_valid, eb_err;
  logic [3:0] bus_type, eb_type;
  logic [7:0] bus_lsb, eb_num;
  logic [REJ_W-1:0] rej_count;
  logic [N_FE-1:0] fe_mismatch;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trig_sync_top i_trig_sync_top (
    .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .trig_req(trig_req),
    .trig_type(trig_type), .dly_en(dly_en), .dly_cycles(dly_cycles),
    .dly_type(dly_type), .fe_en(fe_en), .eb_ready(eb_ready),
    .bus_strb(bus_strb), .bus_type(bus_type), .bus_lsb(bus_lsb),
    .busy(busy), .rej_count(rej_count), .fe_mismatch(fe_mismatch),
    .eb_valid(eb_valid), .eb_type(eb_type), .eb_num(eb_num), .eb_err(eb_err)
  );

  // vector: {class, expected event number}
  localparam logic [11:0] VEC [8] = '{
    {4'h3, 8'd0}, {4'hA, 8'd1}, {4'h0, 8'd2}, {4'hF, 8'd3},
    {4'h5, 8'd4}, {4'h9, 8'd5}, {4'h1, 8'd6}, {4'hC, 8'd7}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives a one-cycle request; returns on the falling edge where the strobe is due
  task automatic trig(input logic [3:0] c);
    trig_req  = 1'b1;
    trig_type = c;
    @(negedge clk);
    trig_req  = 1'b0;
  endtask

  task automatic clear();
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 strb", int'(bus_strb), 0);
    chk("R9 busy", int'(busy), 0);
    chk("R9 eb_valid", int'(eb_valid), 0);
    chk("R9 rej", int'(rej_count), 0);
    chk("R9 mismatch", int'(fe_mismatch), 0);

    // R1 R2 R8 vector table
    eb_ready = 1'b1;
    for (int v = 0; v < 8; v++) begin
      trig(VEC[v][11:8]);
      chk("R1 strb", int'(bus_strb), 1);
      chk("R1 type", int'(bus_type), int'(VEC[v][11:8]));
      chk("R1 lsb", int'(bus_lsb), int'(VEC[v][7:0]));
      @(negedge clk);
      chk("R1 strb one cycle", int'(bus_strb), 0);
      chk("R2 valid", int'(eb_valid), 1);
      chk("R2 type", int'(eb_type), int'(VEC[v][11:8]));
      chk("R2 num", int'(eb_num), int'(VEC[v][7:0]));
      chk("R8 no err", int'(eb_err), 0);
    end
    @(negedge clk);
    chk("R2 drained", int'(eb_valid), 0);
    eb_ready = 1'b0;

    // R9 clear restarts numbering
    clear();
    trig(4'h2);
    chk("R9 lsb after clear", int'(bus_lsb), 0);
    @(negedge clk);
    // R2 hold while not ready
    chk("R2 held valid", int'(eb_valid), 1);
    @(negedge clk);
    chk("R2 still held", int'(eb_num), 0);

    // R3 R4 busy: buffer at 1, add 2 more -> 3, then back-to-back requests
    trig(4'h2); @(negedge clk);
    trig(4'h2); @(negedge clk);
    trig_req = 1'b1; trig_type = 4'h7;
    @(negedge clk);
    chk("R3 accepted at DEPTH-1", int'(bus_strb), 1);
    chk("R3 busy in flight", int'(busy), 1);
    @(negedge clk);
    trig_req = 1'b0;
    chk("R4 refused strb", int'(bus_strb), 0);
    chk("R4 rej", int'(rej_count), 1);
    chk("R3 busy full", int'(busy), 1);
    trig(4'h7);
    chk("R4 refused again", int'(bus_strb), 0);
    @(negedge clk);
    chk("R4 rej 2", int'(rej_count), 2);
    eb_ready = 1'b1;
    @(negedge clk);
    eb_ready = 1'b0;
    chk("R3 released", int'(busy), 0);

    // R5 delayed trigger
    clear();
    eb_ready = 1'b1;
    dly_en = 1'b1; dly_cycles = 16'd5; dly_type = 4'hD;
    trig(4'h1);
    chk("R5 primary", int'(bus_strb), 1);
    seen = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (bus_strb && seen == 0) begin
        seen = k;
        chk("R5 delayed type", int'(bus_type), 13);
        chk("R1 delayed lsb", int'(bus_lsb), 1);
      end
    end
    chk("R5 delay cycles", seen, 5);
    dly_en = 1'b0;

    // R6 suppression while busy
    clear();
    eb_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      trig(4'h4); @(negedge clk);
    end
    dly_en = 1'b1; dly_cycles = 16'd3;
    trig(4'h4);
    chk("R6 primary", int'(bus_strb), 1);
    dly_en = 1'b0;
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (bus_strb) seen++;
    end
    chk("R6 no delayed strb", seen, 0);
    chk("R6 rej", int'(rej_count), 1);

    // R10 R7 R8 mismatch
    clear();
    fe_en = 4'b1011;
    trig(4'h6);
    @(negedge clk);
    chk("R10 node ignored", int'(eb_valid), 0);
    fe_en = 4'b1111;
    trig(4'h6);
    @(negedge clk);
    chk("R7 mismatch flag", int'(fe_mismatch), 4);
    trig(4'h6);
    @(negedge clk);
    chk("R8 first aligned", int'(eb_err), 0);
    chk("R8 first num", int'(eb_num), 0);
    eb_ready = 1'b1;
    @(negedge clk);
    eb_ready = 1'b0;
    chk("R8 second valid", int'(eb_valid), 1);
    chk("R8 err", int'(eb_err), 1);
    chk("R7 sticky", int'(fe_mismatch), 4);
    eb_ready = 1'b1;
    @(negedge clk);
    eb_ready = 1'b0;
    chk("R7 node realigned", int'(eb_valid), 0);

    // R9 clear removes everything
    clear();
    chk("R9 clr mismatch", int'(fe_mismatch), 0);
    chk("R9 clr valid", int'(eb_valid), 0);
    chk("R9 clr busy", int'(busy), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule